// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block lives inside a DDR SDRAM controller. It turns one host request into the two register-load commands that a DDR device needs at start-up. The request carries the burst length code, the burst type, the read latency code, the DLL-reset flag and a 12-bit word for the extended register. The block first checks the request against the legal encodings. It turns away an illegal request with a single error pulse and issues nothing for it.

A legal request is latched and the block raises busy. It then waits until the bank state tracker reports every bank idle and the clock-enable tracker reports the clock enabled. When both hold, it drives the extended register load (bank address 01, host word on the address bus). Two command-free cycles follow. It then waits for the same condition again and drives the main register load (bank address 00, fields packed into the address bus). Two more command-free cycles follow, and done pulses in the second of them while busy falls. The command strobes are active low, and every strobe stays high in every cycle that is not an issue cycle.

Top module: `ddr_mrs_seq`

## Requirements
- R1: While reset is held and after it is released with no request, cmd_cs_n, cmd_ras_n, cmd_cas_n and cmd_we_n are 1, and busy, done and err are 0.
- R2: For each accepted request, the first command issued has all four strobes low, cmd_ba = 01 and cmd_addr equal to req_ext_word.
- R3: The second command issued has cmd_ba = 00 and cmd_addr[2:0] = burst length code, [3] = burst type, [6:4] = latency code, [7] = 0, [8] = DLL-reset flag, [11:9] = 0.
- R4: A command appears on the pins only in the cycle after a clock edge at which banks_idle and cke_high were both 1. Otherwise the block keeps waiting.
- R5: Each command is followed by at least two cycles with cmd_cs_n = 1. The main register command appears no earlier than three cycles after the extended one.
- R6: busy is 1 from the cycle after a legal request is sampled until done pulses. done is high for exactly one cycle, two cycles after the main register command. busy is 0 in that cycle.
- R7: Burst length codes 001, 010 and 011 are legal. Code 111 is legal only with burst type 0. Any other code, or 111 with burst type 1, gives err = 1 for exactly the cycle after the request is sampled, with busy 0 and no command.
- R8: Latency codes 010, 011, 100 and 110 are legal. Any other code is rejected like R7.
- R9: req_valid is ignored while busy is 1. The commands issued are those of the request that was accepted.
- R10: Outside an issue cycle, all four command strobes are 1. In an issue cycle all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_bl | input | 3 | Burst length code |
| req_bt | input | 1 | Burst type, 0 sequential, 1 interleave |
| req_cl | input | 3 | Read latency code |
| req_dll | input | 1 | DLL-reset flag |
| req_ext_word | input | 12 | Word for the extended register |
| banks_idle | input | 1 | All banks precharged |
| cke_high | input | 1 | Clock enable already high |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_addr | output | 12 | Address bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-request pulse |

## Verification
The assertions assume that the readiness inputs describe the device honestly. They also assume that the host presents fields and req_valid together for one sampled edge and does not rely on any request made while busy. The stimulus mixes directed legal and reserved codes with seeded random fields. It toggles banks_idle and cke_high randomly during some sequences to exercise waiting. It also injects a stray request mid-sequence to check that it is ignored. Inputs always change away from the active edge.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_EXT,
    ST_GAP_EXT,
    ST_WAIT_MODE,
    ST_GAP_MODE
  } seq_state_t;

  localparam logic [1:0] BA_MODE = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b01;
endpackage

// File: rtl/ddr_mrs_check.sv
module ddr_mrs_check #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        bl,
  input  logic              bt,
  input  logic [2:0]        cl,
  input  logic              dll,
  output logic              legal,
  output logic [ADDR_W-1:0] mode_word
);
  logic bl_ok;
  logic cl_ok;

  always_comb begin
    unique case (bl)
      3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
      3'b111:                 bl_ok = ~bt;   // full page: sequential only
      default:                bl_ok = 1'b0;
    endcase
    unique case (cl)
      3'b010, 3'b011, 3'b100, 3'b110: cl_ok = 1'b1;
      default:                        cl_ok = 1'b0;
    endcase
    legal = bl_ok & cl_ok;
  end

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = bl;
    mode_word[3]   = bt;
    mode_word[6:4] = cl;
    mode_word[7]   = 1'b0;   // test mode kept off
    mode_word[8]   = dll;
  end
endmodule

// File: rtl/ddr_mrs_fsm.sv
module ddr_mrs_fsm
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_legal,
  input  logic [ADDR_W-1:0] req_mode_word,
  input  logic [ADDR_W-1:0] req_ext_word,
  input  logic              banks_idle,
  input  logic              cke_high,
  output logic              issue_ext,
  output logic              issue_mode,
  output logic [ADDR_W-1:0] ext_word,
  output logic [ADDR_W-1:0] mode_word,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_CYC - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             ready;

  assign ready      = banks_idle & cke_high;
  assign issue_ext  = (state == ST_WAIT_EXT)  & ready;
  assign issue_mode = (state == ST_WAIT_MODE) & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      ext_word  <= '0;
      mode_word <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_legal) begin
              ext_word  <= req_ext_word;
              mode_word <= req_mode_word;
              busy      <= 1'b1;
              state     <= ST_WAIT_EXT;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_WAIT_EXT: begin
          if (ready) begin
            cnt   <= '0;
            state <= ST_GAP_EXT;
          end
        end
        ST_GAP_EXT: begin
          if (cnt == LAST) state <= ST_WAIT_MODE;
          else             cnt   <= cnt + 1'b1;
        end
        ST_WAIT_MODE: begin
          if (ready) begin
            cnt   <= '0;
            state <= ST_GAP_MODE;
          end
        end
        ST_GAP_MODE: begin
          if (cnt == LAST) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err |=> !err); // R7
  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R6
endmodule

// File: rtl/ddr_mrs_cmdreg.sv
module ddr_mrs_cmdreg
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_ext,
  input  logic              issue_mode,
  input  logic [ADDR_W-1:0] ext_word,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba   <= '0;
      addr <= '0;
    end else if (issue_ext) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0000;
      ba   <= BA_EXT;
      addr <= ext_word;
    end else if (issue_mode) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0000;
      ba   <= BA_MODE;
      addr <= mode_word;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
    end
  end

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (rst)
    !(issue_ext && issue_mode)); // R2
endmodule

// File: rtl/ddr_mrs_seq.sv
module ddr_mrs_seq
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_bl,
  input  logic              req_bt,
  input  logic [2:0]        req_cl,
  input  logic              req_dll,
  input  logic [ADDR_W-1:0] req_ext_word,
  input  logic              banks_idle,
  input  logic              cke_high,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [1:0]        cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic              legal;
  logic [ADDR_W-1:0] chk_word;
  logic              issue_ext;
  logic              issue_mode;
  logic [ADDR_W-1:0] ext_q;
  logic [ADDR_W-1:0] mode_q;

  ddr_mrs_check #(.ADDR_W(ADDR_W)) check_i (
    .bl(req_bl), .bt(req_bt), .cl(req_cl), .dll(req_dll),
    .legal(legal), .mode_word(chk_word)
  );

  ddr_mrs_fsm #(.ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)) fsm_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_legal(legal),
    .req_mode_word(chk_word), .req_ext_word(req_ext_word),
    .banks_idle(banks_idle), .cke_high(cke_high),
    .issue_ext(issue_ext), .issue_mode(issue_mode),
    .ext_word(ext_q), .mode_word(mode_q),
    .busy(busy), .done(done), .err(err)
  );

  ddr_mrs_cmdreg #(.ADDR_W(ADDR_W)) cmdreg_i (
    .clk(clk), .rst(rst), .issue_ext(issue_ext), .issue_mode(issue_mode),
    .ext_word(ext_q), .mode_word(mode_q),
    .cs_n(cmd_cs_n), .ras_n(cmd_ras_n), .cas_n(cmd_cas_n), .we_n(cmd_we_n),
    .ba(cmd_ba), .addr(cmd_addr)
  );

  AST_CMD_READY: assert property (@(posedge clk) disable iff (rst)
    !cmd_cs_n |-> $past(banks_idle && cke_high)); // R4
  AST_CMD_GAP: assert property (@(posedge clk) disable iff (rst)
    !cmd_cs_n |=> cmd_cs_n ##1 cmd_cs_n); // R5
  AST_CMD_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cmd_cs_n |-> busy); // R6
  AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $countones({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}) inside {0, 4}); // R10
  AST_TM_LOW: assert property (@(posedge clk) disable iff (rst)
    (!cmd_cs_n && cmd_ba == BA_MODE) |-> (!cmd_addr[7] && cmd_addr[ADDR_W-1:9] == '0)); // R3
endmodule

// File: tb/ddr_mrs_seq_tb.sv
`timescale 1ns/1ps
module ddr_mrs_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_bl = '0;
  logic        req_bt = 1'b0;
  logic [2:0]  req_cl = '0;
  logic        req_dll = 1'b0;
  logic [11:0] req_ext_word = '0;
  logic        banks_idle = 1'b1;
  logic        cke_high = 1'b1;
  logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0]  cmd_ba;
  logic [11:0] cmd_addr;
  logic        busy, done, err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ddr_mrs_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bl(req_bl), .req_bt(req_bt),
    .req_cl(req_cl), .req_dll(req_dll), .req_ext_word(req_ext_word),
    .banks_idle(banks_idle), .cke_high(cke_high),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_legal(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
    bit b_ok = (bl == 3'd1) || (bl == 3'd2) || (bl == 3'd3) || (bl == 3'd7 && !bt);
    bit c_ok = (cl == 3'd2) || (cl == 3'd3) || (cl == 3'd4) || (cl == 3'd6);
    return b_ok && c_ok;
  endfunction

  function automatic logic [11:0] exp_mode(input logic [2:0] bl, input logic bt,
                                          input logic [2:0] cl, input logic dll);
    return {3'b000, dll, 1'b0, cl, bt, bl};
  endfunction

  task automatic run_req(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                         input logic dll, input logic [11:0] ext, input bit stall,
                         input bit stray);
    bit legal = exp_legal(bl, bt, cl);
    logic [11:0] mword = exp_mode(bl, bt, cl, dll);
    int n = 0, ncmd = 0, cyc_e = 0, cyc_m = 0;
    bit rdy_prev, seen_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_bl = bl; req_bt = bt; req_cl = cl; req_dll = dll; req_ext_word = ext;
    banks_idle = 1'b1; cke_high = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!legal) begin
      chk(err == 1'b1, "R7/R8 err pulse", err, 1);
      chk(busy == 1'b0, "R7/R8 no busy", busy, 0);
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(cmd_cs_n == 1'b1 && err == 1'b0 && busy == 1'b0, "R7 no command after reject",
            {cmd_cs_n, err, busy}, 3'b100);
      end
      return;
    end
    chk(busy == 1'b1 && err == 1'b0, "R6 busy on accept", {busy, err}, 2'b10);
    if (stall) begin
      banks_idle = ($urandom % 3) != 0;
      cke_high   = ($urandom % 4) != 0;
    end
    while (n < 300) begin
      rdy_prev = banks_idle && cke_high;
      @(negedge clk);
      n++;
      if (stray) req_valid = (n == 1);
      if (stray && n == 1) begin
        req_bl = 3'd2; req_bt = ~bt; req_cl = 3'd3; req_dll = ~dll; req_ext_word = ~ext;
      end
      if (!cmd_cs_n) begin
        ncmd++;
        chk(rdy_prev, "R4 command only after ready", rdy_prev, 1);
        chk({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b000, "R10 strobes low in issue",
            {cmd_ras_n, cmd_cas_n, cmd_we_n}, 0);
        if (ncmd == 1) begin
          cyc_e = n;
          chk(cmd_ba == 2'b01, "R2 ext bank", cmd_ba, 1);
          chk(cmd_addr == ext, "R2/R9 ext word", cmd_addr, ext);
        end else begin
          cyc_m = n;
          chk(cmd_ba == 2'b00, "R3 mode bank", cmd_ba, 0);
          chk(cmd_addr == mword, "R3/R9 mode word", cmd_addr, mword);
          chk(cyc_m - cyc_e >= 3, "R5 gap ext to mode", cyc_m - cyc_e, 3);
        end
      end else begin
        chk({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b111, "R10 strobes high idle",
            {cmd_ras_n, cmd_cas_n, cmd_we_n}, 7);
      end
      if (done) begin
        seen_done = 1;
        chk(ncmd == 2, "R2/R3 two commands", ncmd, 2);
        chk(n - cyc_m == 2, "R6 done timing", n - cyc_m, 2);
        chk(busy == 1'b0, "R6 busy falls with done", busy, 0);
        break;
      end else begin
        chk(busy == 1'b1, "R6 busy held", busy, 1);
      end
      if (stall) begin
        banks_idle = ($urandom % 3) != 0;
        cke_high   = ($urandom % 4) != 0;
      end
    end
    req_valid = 1'b0;
    banks_idle = 1'b1; cke_high = 1'b1;
    chk(seen_done, "R6 sequence completes", seen_done, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R6 done single cycle", {done, busy}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    chk({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'hF, "R1 strobes in reset",
        {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 15);
    chk({busy, done, err} == 3'b000, "R1 flags in reset", {busy, done, err}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({cmd_cs_n, busy, done, err} == 4'b1000, "R1 idle after reset",
        {cmd_cs_n, busy, done, err}, 8);

    // directed: each legal burst length, full page, latencies
    run_req(3'd1, 1'b0, 3'd2, 1'b1, 12'h040, 0, 0); // R7 R3
    run_req(3'd2, 1'b1, 3'd3, 1'b0, 12'h002, 0, 0); // R7
    run_req(3'd3, 1'b1, 3'd4, 1'b1, 12'hABC, 0, 0); // R8
    run_req(3'd7, 1'b0, 3'd6, 1'b0, 12'h000, 0, 0); // R7 full page seq, R8 half-cycle
    run_req(3'd7, 1'b1, 3'd3, 1'b0, 12'h123, 0, 0); // R7 full page interleave rejected
    run_req(3'd0, 1'b0, 3'd3, 1'b0, 12'h123, 0, 0); // R7
    run_req(3'd5, 1'b0, 3'd2, 1'b0, 12'h123, 0, 0); // R7
    run_req(3'd2, 1'b0, 3'd1, 1'b0, 12'h123, 0, 0); // R8
    run_req(3'd2, 1'b0, 3'd5, 1'b0, 12'h123, 0, 0); // R8
    run_req(3'd2, 1'b0, 3'd7, 1'b0, 12'h123, 0, 0); // R8
    run_req(3'd3, 1'b0, 3'd3, 1'b1, 12'hFFF, 1, 0); // R4 stalls
    run_req(3'd1, 1'b1, 3'd2, 1'b0, 12'h5A5, 0, 1); // R9 stray request
    run_req(3'd2, 1'b0, 3'd6, 1'b1, 12'h3C3, 1, 1); // R9 with stalls

    for (int k = 0; k < 60; k++) begin
      run_req(3'($urandom % 8), 1'($urandom % 2), 3'($urandom % 8), 1'($urandom % 2),
              12'($urandom), bit'($urandom % 2), bit'(($urandom % 4) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule